// File: doc/BRIEF.md
# Smart-Card Line Listener

This block taps the three lines of a smart-card interface: reset, card clock and the shared data line. It rebuilds every asynchronous character that crosses the data line. The card and the terminal take turns on one wire, so the block cannot tell which side sent a character. It never drives the bus. All three lines are first brought into the system clock domain.

Bit timing is not measured in system clock cycles. It is measured by counting rising edges of the card clock, in units of a half elementary time unit (half-etu). A falling edge on the idle data line opens a character. The start bit is confirmed one half-etu later. The nine following bits (eight data bits and parity) are each sampled two half-etus apart. One more sample, in the guard time, detects a receiver's error signal.

Every card-reset edge is reported as an event and reloads the half-etu count with its session default. A protocol-aware controller can overwrite the count during the session after a speed change.

Top module: `scard_sniffer`

## Requirements
- R1: Each card input passes through a two-flop synchronizer. A level change on `card_rst_in` that is applied between two system clock edges makes `rst_evt` high after the second following edge, for exactly one cycle.
- R2: Every edge of the synchronized reset line produces a one-cycle `rst_evt`. During that cycle `rst_evt_level` holds the new level (1 = released, 0 = asserted).
- R3: A rising edge of the synchronized reset line, and the system reset, load the half-etu count with `HETU_RST` (default 186, which is F/D = 372).
- R4: A cycle with `hetu_load` high writes `hetu_value` into the half-etu count, unless a reset-line rising edge is seen in the same cycle. Later characters are timed with the new count.
- R5: A character starts on a high-to-low edge of the synchronized data line while reset is high. Counting starts from the next rising edge of the card clock. The line is sampled at rise H, then every 2·H rises: nine bits, then one guard sample.
- R6: Bits are delivered in arrival order without inversion. The first data bit lands in `char_data[0]`, the eighth in `char_data[7]`, and the ninth bit goes to `char_parity`.
- R7: If the data line is high at the start-bit midpoint, the event is discarded, no character is reported, and the receiver waits for the next falling edge.
- R8: `char_errsig` is 1 when the data line is low at the guard-time sample that follows the parity bit, and 0 otherwise.
- R9: While the synchronized reset line is low, the receiver stays idle and reports no character, whatever the data line does.
- R10: `char_valid` is high for exactly one system cycle per character. It is asserted in the cycle after the guard sample, and the character fields stay stable until the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_rst_in | input | 1 | Raw card reset line |
| card_clk_in | input | 1 | Raw card clock line |
| card_io_in | input | 1 | Raw card data line |
| hetu_load | input | 1 | Write strobe for the half-etu count |
| hetu_value | input | HETU_W | New half-etu count, in card-clock cycles |
| char_valid | output | 1 | One-cycle strobe: a character is ready |
| char_data | output | 8 | Eight data bits, in arrival order |
| char_parity | output | 1 | Ninth received bit, as received |
| char_errsig | output | 1 | Error signal seen in the guard time |
| rst_evt | output | 1 | One-cycle strobe on a reset-line edge |
| rst_evt_level | output | 1 | New reset-line level during `rst_evt` |

## Verification
If the bit counter or its phase is off, the bits come out shifted or misplaced in the next reported character, so a known byte pattern shows the error within one character time. If the receiver state is stuck, strobes go missing or appear extra: a glitch that produces a character, or a character that is lost while reset is high. A half-etu count that was not reloaded shows up on the first character sent at the default rate after a reset edge. The reset-event strobe is checked down to its exact cycle, because its timing depends only on the synchronizer depth.

// File: rtl/scard_sniff_pkg.sv
`timescale 1ns/1ps
package scard_sniff_pkg;

    localparam int DATA_W   = 8;
    localparam int FRAME_W  = DATA_W + 1;   // data bits plus parity

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_GUARD
    } rx_state_e;

    typedef struct packed {
        logic              errsig;
        logic              parity;
        logic [DATA_W-1:0] data;
    } char_rec_t;

endpackage

// File: rtl/scard_sync.sv
`timescale 1ns/1ps
module scard_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scard_hetu_reg.sv
`timescale 1ns/1ps
module scard_hetu_reg #(
    parameter int HETU_W   = 8,
    parameter int HETU_RST = 186
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_rst,
    input  logic              ld,
    input  logic [HETU_W-1:0] ld_val,
    output logic [HETU_W-1:0] hetu,
    output logic              rst_evt,
    output logic              rst_evt_level
);
    localparam logic [HETU_W-1:0] RST_VAL = HETU_W'(HETU_RST);

    logic rst_prev;
    logic rst_rise;

    assign rst_rise = s_rst & ~rst_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_prev <= 1'b0;
            hetu     <= RST_VAL;
        end else begin
            rst_prev <= s_rst;
            if (rst_rise) begin
                hetu <= RST_VAL;
            end else if (ld) begin
                hetu <= ld_val;
            end
        end
    end

    assign rst_evt       = s_rst ^ rst_prev;
    assign rst_evt_level = s_rst;

    // R3: a session-opening edge restores the default count
    p_hetu_reload_r3: assert property (@(posedge clk) disable iff (rst)
        rst_rise |=> hetu == RST_VAL);

    // R4: an external write lands one cycle later
    p_hetu_write_r4: assert property (@(posedge clk) disable iff (rst)
        (ld && !rst_rise) |=> hetu == $past(ld_val));

    // R4: without a write or reload the count holds
    p_hetu_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ld && !rst_rise) |=> $stable(hetu));
endmodule

// File: rtl/scard_char_rx.sv
`timescale 1ns/1ps
module scard_char_rx
    import scard_sniff_pkg::*;
#(
    parameter int HETU_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_rst,
    input  logic              s_clk,
    input  logic              s_io,
    input  logic [HETU_W-1:0] hetu,
    output logic              char_valid,
    output char_rec_t         rec
);
    localparam int CNT_W = HETU_W + 1;
    localparam int IDX_W = $clog2(FRAME_W + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] shreg;
    logic               clk_prev;
    logic               io_prev;

    logic               clk_rise;
    logic               io_fall;
    logic [CNT_W-1:0]   half_last;
    logic [CNT_W-1:0]   full_last;

    assign clk_rise  = s_clk & ~clk_prev;
    assign io_fall   = ~s_io & io_prev;
    assign half_last = {1'b0, hetu} - CNT_W'(1);
    assign full_last = {hetu, 1'b0} - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            clk_prev   <= 1'b0;
            io_prev    <= 1'b1;
            char_valid <= 1'b0;
            rec        <= '0;
        end else begin
            clk_prev   <= s_clk;
            io_prev    <= s_io;
            char_valid <= 1'b0;
            if (!s_rst) begin
                state <= RX_IDLE;
                cnt   <= '0;
            end else begin
                unique case (state)
                    RX_IDLE: begin
                        if (io_fall) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (clk_rise) begin
                            if (cnt >= half_last) begin
                                cnt <= '0;
                                if (s_io) begin
                                    state <= RX_IDLE;
                                end else begin
                                    state   <= RX_BITS;
                                    bit_idx <= '0;
                                end
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    RX_BITS: begin
                        if (clk_rise) begin
                            if (cnt >= full_last) begin
                                cnt            <= '0;
                                shreg[bit_idx] <= s_io;
                                if (bit_idx == LAST_IDX) begin
                                    state <= RX_GUARD;
                                end else begin
                                    bit_idx <= bit_idx + IDX_W'(1);
                                end
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    RX_GUARD: begin
                        if (clk_rise) begin
                            if (cnt >= full_last) begin
                                cnt        <= '0;
                                state      <= RX_IDLE;
                                char_valid <= 1'b1;
                                rec.data   <= shreg[DATA_W-1:0];
                                rec.parity <= shreg[DATA_W];
                                rec.errsig <= ~s_io;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R9: a low card reset forces the receiver idle
    p_idle_rst_low_r9: assert property (@(posedge clk) disable iff (rst)
        !s_rst |=> state == RX_IDLE);

    // R10: the character strobe never lasts two cycles
    p_single_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid);

    // R8: a character is only delivered out of the guard phase
    p_strobe_after_guard_r8: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> $past(state) == RX_GUARD);

    // R7: a high line at start midpoint drops back to idle with no strobe
    p_glitch_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && clk_rise && cnt >= half_last && s_io && s_rst)
        |=> (state == RX_IDLE && !char_valid));

    // R6: the bit index never runs past the ninth bit
    p_bit_index_r6: assert property (@(posedge clk) disable iff (rst)
        bit_idx <= LAST_IDX);
endmodule

// File: rtl/scard_sniffer.sv
`timescale 1ns/1ps
module scard_sniffer
    import scard_sniff_pkg::*;
#(
    parameter int HETU_W      = 8,
    parameter int HETU_RST    = 186,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              card_rst_in,
    input  logic              card_clk_in,
    input  logic              card_io_in,
    input  logic              hetu_load,
    input  logic [HETU_W-1:0] hetu_value,
    output logic              char_valid,
    output logic [DATA_W-1:0] char_data,
    output logic              char_parity,
    output logic              char_errsig,
    output logic              rst_evt,
    output logic              rst_evt_level
);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               s_rst;
    logic               s_clk;
    logic               s_io;
    logic [HETU_W-1:0]  hetu;
    char_rec_t          rec;

    assign raw_lines = {card_rst_in, card_clk_in, card_io_in};

    scard_sync #(
        .W      (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    assign s_rst = sync_lines[2];
    assign s_clk = sync_lines[1];
    assign s_io  = sync_lines[0];

    scard_hetu_reg #(
        .HETU_W   (HETU_W),
        .HETU_RST (HETU_RST)
    ) u_hetu (
        .clk           (clk),
        .rst           (rst),
        .s_rst         (s_rst),
        .ld            (hetu_load),
        .ld_val        (hetu_value),
        .hetu          (hetu),
        .rst_evt       (rst_evt),
        .rst_evt_level (rst_evt_level)
    );

    scard_char_rx #(
        .HETU_W (HETU_W)
    ) u_rx (
        .clk        (clk),
        .rst        (rst),
        .s_rst      (s_rst),
        .s_clk      (s_clk),
        .s_io       (s_io),
        .hetu       (hetu),
        .char_valid (char_valid),
        .rec        (rec)
    );

    assign char_data   = rec.data;
    assign char_parity = rec.parity;
    assign char_errsig = rec.errsig;

    // R10: a delivered character comes with reset released
    p_valid_needs_rst_r10: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> $past(s_rst));
endmodule

// File: tb/scard_sniffer_tb_top.sv
`timescale 1ns/1ps
module scard_sniffer_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       card_rst_in;
    logic       card_clk_in;
    logic       card_io_in;
    logic       hetu_load;
    logic [7:0] hetu_value;
    logic       char_valid;
    logic [7:0] char_data;
    logic       char_parity;
    logic       char_errsig;
    logic       rst_evt;
    logic       rst_evt_level;

    int n_chk  = 0;
    int n_bad  = 0;
    int n_val  = 0;
    int n_evt  = 0;
    int n_dbl  = 0;
    logic       prev_val = 1'b0;
    logic [7:0] got_data;
    logic       got_par;
    logic       got_err;
    logic       finished = 1'b0;

    // {errsig, parity, data}
    localparam int NVEC = 5;
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'h3B},
        {1'b0, 1'b0, 8'hFF},
        {1'b1, 1'b0, 8'h00},
        {1'b1, 1'b1, 8'hA5},
        {1'b0, 1'b0, 8'h81}
    };

    always #2.5 clk = ~clk;

    scard_sniffer dut_i (
        .clk           (clk),
        .rst           (rst),
        .card_rst_in   (card_rst_in),
        .card_clk_in   (card_clk_in),
        .card_io_in    (card_io_in),
        .hetu_load     (hetu_load),
        .hetu_value    (hetu_value),
        .char_valid    (char_valid),
        .char_data     (char_data),
        .char_parity   (char_parity),
        .char_errsig   (char_errsig),
        .rst_evt       (rst_evt),
        .rst_evt_level (rst_evt_level)
    );

    // card clock: 4 system cycles per period
    initial begin
        card_clk_in = 1'b0;
        forever begin
            repeat (2) @(negedge clk);
            card_clk_in = ~card_clk_in;
        end
    end

    always @(negedge clk) begin
        if (char_valid) begin
            n_val++;
            got_data = char_data;
            got_par  = char_parity;
            got_err  = char_errsig;
            if (prev_val) n_dbl++;
        end
        prev_val = char_valid;
        if (rst_evt) n_evt++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_rises(input int n);
        repeat (n) @(posedge card_clk_in);
        @(negedge clk);
    endtask

    task automatic send_char(input int h, input logic [7:0] d,
                             input logic p, input logic e);
        wait_rises(1);
        card_io_in = 1'b0;
        wait_rises(2 * h);
        for (int i = 0; i < 8; i++) begin
            card_io_in = d[i];
            wait_rises(2 * h);
        end
        card_io_in = p;
        wait_rises(2 * h);
        card_io_in = e ? 1'b0 : 1'b1;
        wait_rises(2 * h);
        card_io_in = 1'b1;
        wait_rises(2 * h);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        int base;
        rst         = 1'b1;
        card_rst_in = 1'b0;
        card_io_in  = 1'b1;
        hetu_load   = 1'b0;
        hetu_value  = '0;
        repeat (5) @(negedge clk);
        // reset state
        chk("R10 reset valid", int'(char_valid), 0);
        chk("R2 reset evt", int'(rst_evt), 0);
        chk("R6 reset data", int'(char_data), 0);
        rst = 1'b0;

        // R1 / R2: release card reset, exact strobe cycle
        @(negedge clk);
        card_rst_in = 1'b1;
        @(negedge clk);
        chk("R1 evt early", int'(rst_evt), 0);
        @(negedge clk);
        chk("R1 evt on time", int'(rst_evt), 1);
        chk("R2 level high", int'(rst_evt_level), 1);
        @(negedge clk);
        chk("R1 evt one cycle", int'(rst_evt), 0);

        // R4: faster rate
        hetu_value = 8'd3;
        hetu_load  = 1'b1;
        @(negedge clk);
        hetu_load  = 1'b0;
        wait_rises(4);

        // R5 R6 R8: vector table
        for (int v = 0; v < NVEC; v++) begin
            base = n_val;
            send_char(3, VEC[v][7:0], VEC[v][8], VEC[v][9]);
            chk("R5 one char", n_val - base, 1);
            chk("R6 data", int'(got_data), int'(VEC[v][7:0]));
            chk("R6 parity", int'(got_par), int'(VEC[v][8]));
            chk("R8 errsig", int'(got_err), int'(VEC[v][9]));
        end
        chk("R4 rate used", n_val, NVEC);

        // R7: short low pulse
        base = n_val;
        wait_rises(1);
        card_io_in = 1'b0;
        wait_rises(1);
        card_io_in = 1'b1;
        wait_rises(12);
        chk("R7 glitch dropped", n_val - base, 0);
        send_char(3, 8'h5A, 1'b0, 1'b0);
        chk("R7 recovered count", n_val - base, 1);
        chk("R7 recovered data", int'(got_data), 8'h5A);
        chk("R10 single strobe", n_dbl, 0);

        // R9: card reset low blocks reception
        card_rst_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 fall evt", int'(rst_evt), 1);
        chk("R2 level low", int'(rst_evt_level), 0);
        base = n_val;
        send_char(3, 8'hC3, 1'b0, 1'b0);
        chk("R9 no char", n_val - base, 0);

        // R3: release reloads default count
        base = n_evt;
        card_rst_in = 1'b1;
        wait_rises(4);
        chk("R2 rise evt counted", n_evt - base, 1);
        base = n_val;
        send_char(186, 8'h96, 1'b1, 1'b1);
        chk("R3 default count", n_val - base, 1);
        chk("R3 data", int'(got_data), 8'h96);
        chk("R3 errsig", int'(got_err), 1);
        chk("R10 single strobe end", n_dbl, 0);

        summary();
    end
endmodule